// File: doc/BRIEF.md
# Internal Oscillator Postscaler Selector

This block picks the rate of the system clock enable inside an internal clock generator. Two free-running references reach it as single-cycle enable pulses on a fast sampling clock: a 16 MHz high-frequency reference and a slow reference of about 31 kHz. A 3-bit frequency code, held in a small register that software loads with a write strobe, selects one of three things. It can pick one of several power-of-two divisions of the high-frequency reference, the high-frequency reference undivided, or a nominal 31 kHz rate.

At the 31 kHz code, a level input picks the source. Set, it takes the divide-by-512 carry of the high-frequency divider (31.25 kHz). Clear, it takes the slow oscillator. A second output always carries the slow oscillator for the watchdog and clock-monitor logic, whatever the code and the source bit are. The divider is a free-running 9-bit counter. Every division is the carry of one counter stage, so every selected output is a one-cycle pulse. A new code applies from the first high-frequency pulse after the write.

Top module: `hfosc_postscaler`

## Requirements
- R1: While reset is asserted, `sys_tick_o` and `wdt_tick_o` are low. After reset the frequency code is 3'b011, which yields one output pulse per 16 high-frequency pulses (1 MHz).
- R2: For codes 3'b001 to 3'b110, `sys_tick_o` gives one pulse per 2^(7-code) high-frequency pulses. This maps code 1 to 250 kHz and code 6 to 8 MHz.
- R3: For code 3'b111, every high-frequency pulse appears on `sys_tick_o` one cycle later (16 MHz).
- R4: For code 3'b000 with `hf_src_i` = 1, `sys_tick_o` gives one pulse per 512 high-frequency pulses (31.25 kHz).
- R5: For code 3'b000 with `hf_src_i` = 0, every low-frequency pulse appears on `sys_tick_o` one cycle later, and no other pulse appears.
- R6: `hf_src_i` has no effect on `sys_tick_o` when the code is not 3'b000.
- R7: `wdt_tick_o` repeats every low-frequency pulse one cycle later, for every code and every `hf_src_i` value.
- R8: A code presented with `code_wr_i` high is stored at that clock edge. The output registered at the following edge already uses it. Without `code_wr_i` the stored code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hf_tick_i | input | 1 | High-frequency reference enable pulse (16 MHz) |
| lf_tick_i | input | 1 | Low-frequency reference enable pulse (~31 kHz) |
| code_wr_i | input | 1 | Write strobe for the frequency code |
| code_i | input | 3 | Frequency code to store |
| hf_src_i | input | 1 | Source for code 000: 1 = divide-by-512 tap, 0 = slow oscillator |
| sys_tick_o | output | 1 | Selected system clock enable pulse |
| wdt_tick_o | output | 1 | Slow oscillator pulse for watchdog and clock monitor |

## Verification
The assertions assume that both reference pulses are synchronous to `clk_i` and one cycle wide. They also assume `hf_src_i` is a level that software changes only together with a code write. The stimulus produces the high-frequency pulse either every cycle or every second cycle, and the slow pulse every eighth cycle. It changes `hf_src_i` only in the write cycle. Each measurement window covers a whole multiple of the longest output period, so the pulse count for every code and source setting is exact whatever the divider phase.

// File: rtl/hfosc_ps_pkg.sv
package hfosc_ps_pkg;

  localparam int unsigned CODE_W_DEF = 3;
  localparam int unsigned DIV_W_DEF  = 9;

  // Divider stage used by a nonzero code: highest code takes stage 0.
  function automatic int unsigned stage_of(input int unsigned code,
                                           input int unsigned code_w);
    return ((1 << code_w) - 1) - code;
  endfunction

endpackage

// File: rtl/hfosc_ps_divider.sv
module hfosc_ps_divider #(
  parameter int unsigned DIV_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hf_tick_i,
  output logic [DIV_W:0] tap_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hf_tick_i) cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // Stage k fires on the hf pulse that carries out of the low k bits.
  assign tap_o[0] = hf_tick_i;
  for (genvar k = 1; k <= DIV_W; k++) begin : g_tap
    assign tap_o[k] = hf_tick_i & (&cnt_q[k-1:0]);
  end

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hf_tick_i |=> $stable(cnt_q));

  p_top_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[DIV_W] |=> (cnt_q == '0));

endmodule

// File: rtl/hfosc_ps_code_reg.sv
module hfosc_ps_code_reg #(
  parameter int unsigned CODE_W     = 3,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (wr_i) code_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= RESET_CODE;
    else         code_q <= code_d;
  end

  assign code_o = code_q;

  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(code_q));

  p_code_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (code_q == $past(code_i)));

endmodule

// File: rtl/hfosc_ps_select.sv
module hfosc_ps_select
  import hfosc_ps_pkg::*;
#(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned DIV_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W:0]    tap_i,
  input  logic              hf_tick_i,
  input  logic              lf_tick_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              hf_src_i,
  output logic              sys_tick_o,
  output logic              wdt_tick_o
);

  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

  logic sys_d, sys_q, wdt_q;
  int unsigned stage;

  always_comb begin
    stage = stage_of(int'(code_i), CODE_W);
    sys_d = 1'b0;
    if (code_i == '0) begin
      sys_d = hf_src_i ? tap_i[DIV_W] : lf_tick_i;
    end else if (stage <= DIV_W) begin
      sys_d = tap_i[stage];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= 1'b0;
      wdt_q <= 1'b0;
    end else begin
      sys_q <= sys_d;
      wdt_q <= lf_tick_i;
    end
  end

  assign sys_tick_o = sys_q;
  assign wdt_tick_o = wdt_q;

  p_full_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == CODE_W'(MAX_CODE) && hf_tick_i) |=> sys_tick_o);

  p_lf_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0 && !hf_src_i) |=> (sys_tick_o == $past(lf_tick_i)));

  p_needs_hf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != '0 && !hf_tick_i) |=> !sys_tick_o);

  p_wdt_fwd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lf_tick_i |=> wdt_tick_o);

endmodule

// File: rtl/hfosc_postscaler.sv
module hfosc_postscaler #(
  parameter int unsigned CODE_W = hfosc_ps_pkg::CODE_W_DEF,
  parameter int unsigned DIV_W  = hfosc_ps_pkg::DIV_W_DEF,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hf_tick_i,
  input  logic              lf_tick_i,
  input  logic              code_wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              hf_src_i,
  output logic              sys_tick_o,
  output logic              wdt_tick_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [DIV_W:0]    tap;
  logic [CODE_W-1:0] code;

  hfosc_ps_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .hf_tick_i (hf_tick_i),
    .tap_o     (tap)
  );

  hfosc_ps_code_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .wr_i   (code_wr_i),
    .code_i (code_i),
    .code_o (code)
  );

  hfosc_ps_select #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tap_i      (tap),
    .hf_tick_i  (hf_tick_i),
    .lf_tick_i  (lf_tick_i),
    .code_i     (code),
    .hf_src_i   (hf_src_i),
    .sys_tick_o (sys_tick_o),
    .wdt_tick_o (wdt_tick_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_n_int |=> (!sys_tick_o && !wdt_tick_o) || rst_n_int);

  p_src_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (code != '0 && !code_wr_i && !hf_tick_i) |=> !sys_tick_o);

endmodule

// File: tb/hfosc_postscaler_tb.sv
module hfosc_postscaler_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hf_tick = 1'b0;
  logic       lf_tick = 1'b0;
  logic       code_wr = 1'b0;
  logic [2:0] code = 3'd0;
  logic       hf_src = 1'b0;
  logic       sys_tick, wdt_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int hf_per = 2;
  bit done = 1'b0;
  logic samp_sys, samp_wdt, first_sys;

  always #(CLK_PERIOD/2) clk = ~clk;

  hfosc_postscaler dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .hf_tick_i  (hf_tick),
    .lf_tick_i  (lf_tick),
    .code_wr_i  (code_wr),
    .code_i     (code),
    .hf_src_i   (hf_src),
    .sys_tick_o (sys_tick),
    .wdt_tick_o (wdt_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample outputs away from the edge, then drive the next cycle's inputs.
  task automatic step();
    @(negedge clk);
    samp_sys = sys_tick;
    samp_wdt = wdt_tick;
    cyc++;
    hf_tick = (hf_per == 1) ? 1'b1 : cyc[0];
    lf_tick = ((cyc % 8) == 0);
  endtask

  function automatic int exp_sys(input int c, input bit src, input int n);
    int hfn;
    hfn = n / hf_per;
    if (c == 0) return src ? (hfn >> 9) : (n / 8);
    return hfn >> (7 - c);
  endfunction

  task automatic window(input string req, input int c, input bit src);
    int n, ns, nw;
    n = 1024 * hf_per;
    ns = 0; nw = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (i == 0) first_sys = samp_sys;
      ns += int'(samp_sys);
      nw += int'(samp_wdt);
    end
    check(req, ns, exp_sys(c, src, n));
    check("R7 watchdog forward", nw, n / 8);
  endtask

  task automatic apply(input int c, input bit src);
    step();
    code_wr = 1'b1;
    code = 3'(c);
    hf_src = src;
    step();
    code_wr = 1'b0;
    code = ~code;
  endtask

  task automatic sweep();
    for (int c = 1; c <= 6; c++) begin
      apply(c, 1'b0);
      window("R2 divided tap", c, 1'b0);
    end
    apply(7, 1'b0);
    window("R3 full rate", 7, 1'b0);
    apply(0, 1'b1);
    window("R4 div512 tap", 0, 1'b1);
    apply(0, 1'b0);
    window("R5 slow source", 0, 1'b0);
    apply(3, 1'b1);
    window("R6 source bit ignored", 3, 1'b1);
    apply(5, 1'b1);
    window("R6 source bit ignored", 5, 1'b1);
  endtask

  initial begin
    // R1: outputs quiet during reset while inputs toggle.
    hf_per = 1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (i > 0) begin
        check("R1 reset sys", int'(samp_sys), 0);
        check("R1 reset wdt", int'(samp_wdt), 0);
      end
    end
    rst_ni = 1'b1;
    hf_per = 2;
    for (int i = 0; i < 4; i++) step();
    window("R1 default code 1MHz", 3, 1'b0);

    sweep();
    hf_per = 1;
    sweep();

    // R8: switch from slow source to full rate; first new output uses new code.
    apply(0, 1'b0);
    window("R5 slow source", 0, 1'b0);
    while ((cyc % 8) != 5) step();
    apply(7, 1'b0);
    window("R3 full rate", 7, 1'b0);
    check("R8 code applies at once", int'(first_sys), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule